// File: doc/BRIEF.md
# Predicated Contiguous Vector Store Sequencer

This block turns one vector store operation into a series of 64-bit memory writes. The caller presents a vector register value, a byte-granular predicate, a base address, a stack-pointer value, a scalar index and two register codes. The block then pulses `start`. The start address is the selected base plus the index scaled by eight. The sequencer visits the elements from lowest to highest. It issues a write only for active elements, and the address moves on by eight bytes for every element, whether or not that element is written.

Two element widths are supported per operation, 64-bit and 128-bit. In both cases each write carries one doubleword, so a 128-bit element contributes only its low half. The index register code 31 is rejected as an undefined operation. A base register code of 31 selects the stack pointer, and a misaligned stack pointer is reported before any write when at least one element is active. Writes leave through a valid/ready port. A one-cycle `done` pulse closes every operation that completes normally.

Top module: `pss_top`

## Requirements
- R1: The first write address is (`base_code_i` == 31 ? `sp_i` : `base_i`) + (`index_i` << 3), modulo 2^64.
- R2: Element e is written at the start address + 8·e, modulo 2^64. The address advances past inactive elements as well.
- R3: An element whose predicate bit is 0 produces no write, and the number of writes equals the number of active elements.
- R4: When `elem_wide_i` = 0, there are VLEN/64 elements, element e is active when `pred_i[8·e]` = 1, and its data is `vec_i[64·e +: 64]`.
- R5: When `elem_wide_i` = 1, there are VLEN/128 elements, element e is active when `pred_i[16·e]` = 1, and the write data is the low doubleword `vec_i[128·e +: 64]`.
- R6: `idx_code_i` = 31 produces a one-cycle `err_undef_o` pulse, and the operation has no write and no `done_o`.
- R7: When `base_code_i` = 31, `sp_i[3:0]` ≠ 0 and at least one element is active (and R6 does not apply), the block produces a one-cycle `err_align_o` pulse, with no write and no `done_o`.
- R8: A misaligned stack pointer with no active element raises no error, and the operation ends with `done_o` and no writes.
- R9: While `wr_valid_o` = 1 and `wr_ready_i` = 0, the same write stays presented with address and data stable in the following cycle.
- R10: `done_o` is a single-cycle pulse after the last element. `busy_o` is high from acceptance until that pulse ends, and `start` is ignored while `busy_o` = 1.
- R11: During and after reset, `wr_valid_o`, `done_o`, `err_undef_o`, `err_align_o` and `busy_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Begin an operation (accepted only when idle) |
| elem_wide_i | input | 1 | Element width: 0 = 64-bit, 1 = 128-bit |
| idx_code_i | input | 5 | Index register code; 31 is undefined |
| base_code_i | input | 5 | Base register code; 31 selects the stack pointer |
| vec_i | input | VLEN | Vector register value |
| pred_i | input | VLEN/8 | Predicate, one bit per vector byte |
| base_i | input | 64 | General base address |
| sp_i | input | 64 | Stack pointer value |
| index_i | input | 64 | Scalar element index |
| wr_valid_o | output | 1 | Write request valid |
| wr_ready_i | input | 1 | Write accepted by memory |
| wr_addr_o | output | 64 | Write byte address |
| wr_data_o | output | 64 | Write doubleword |
| done_o | output | 1 | Operation complete pulse |
| err_undef_o | output | 1 | Undefined index code pulse |
| err_align_o | output | 1 | Stack pointer misalignment pulse |
| busy_o | output | 1 | Operation in progress |

## Verification
Several properties are checked on every cycle by assertions: a stalled write keeps its address and data, done is never longer than one cycle, at most one of done and the two error pulses is high at a time, the address steps by eight between consecutive elements, and the check state leads to the matching error. Only the bench scenarios can show that the written addresses, data and count match the predicate in both element widths. The same holds for address wraparound near the top of the space, for the choice of stack pointer over base, for the skipped alignment check when no element is active, and for a `start` during a busy operation that leaves the running one untouched.

// File: rtl/pss_pkg.sv
package pss_pkg;
  localparam int MEM_W    = 64;
  localparam int ADDR_W   = 64;
  localparam int CODE_W   = 5;
  localparam int STEP_SH  = 3;
  localparam logic [CODE_W-1:0] CODE_SPECIAL = 5'd31;
  localparam int ALIGN_BITS = 4;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RUN   = 2'd2,
    ST_DONE  = 2'd3
  } pss_state_e;
endpackage

// File: rtl/pss_rst_sync.sv
module pss_rst_sync (
  input  logic clk,
  input  logic rst_n_a,
  output logic rst_n_s
);
  logic meta_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n_a) begin
    if (!rst_n_a) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      sync_q <= meta_q;
    end
  end

  assign rst_n_s = sync_q;
endmodule

// File: rtl/pss_addr_gen.sv
module pss_addr_gen
  import pss_pkg::*;
(
  input  logic [CODE_W-1:0] base_code_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] index_i,
  input  logic [ADDR_W-1:0] cur_addr_i,
  output logic [ADDR_W-1:0] start_addr_o,
  output logic [ADDR_W-1:0] next_addr_o,
  output logic              sp_misaligned_o
);
  localparam logic [ADDR_W-1:0] STEP = ADDR_W'(MEM_W / 8);

  logic [ADDR_W-1:0] base_sel;
  logic              use_sp;

  always_comb begin
    use_sp          = (base_code_i == CODE_SPECIAL);
    base_sel        = use_sp ? sp_i : base_i;
    start_addr_o    = base_sel + (index_i << STEP_SH);
    next_addr_o     = cur_addr_i + STEP;
    sp_misaligned_o = use_sp && (sp_i[ALIGN_BITS-1:0] != '0);
  end
endmodule

// File: rtl/pss_elem_sel.sv
module pss_elem_sel
  import pss_pkg::*;
#(
  parameter int VLEN = 256,
  localparam int PW    = VLEN / 8,
  localparam int NE64  = VLEN / 64,
  localparam int NE128 = VLEN / 128,
  localparam int EW    = $clog2(NE64)
) (
  input  logic [VLEN-1:0]  vec_i,
  input  logic [PW-1:0]    pred_i,
  input  logic             wide_i,
  input  logic [EW-1:0]    idx_i,
  output logic [MEM_W-1:0] data_o,
  output logic             active_o,
  output logic             any_active_o
);
  logic [MEM_W-1:0] w64  [NE64];
  logic [MEM_W-1:0] w128 [NE64];
  logic [NE64-1:0]  a64;
  logic [NE64-1:0]  a128;

  for (genvar i = 0; i < NE64; i++) begin : g_lane
    assign w64[i] = vec_i[i*64 +: MEM_W];
    assign a64[i] = pred_i[i*8];
    if (i < NE128) begin : g_wide
      assign w128[i] = vec_i[i*128 +: MEM_W];
      assign a128[i] = pred_i[i*16];
    end else begin : g_none
      assign w128[i] = '0;
      assign a128[i] = 1'b0;
    end
  end

  always_comb begin
    if (wide_i) begin
      data_o       = w128[idx_i];
      active_o     = a128[idx_i];
      any_active_o = |a128;
    end else begin
      data_o       = w64[idx_i];
      active_o     = a64[idx_i];
      any_active_o = |a64;
    end
  end
endmodule

// File: rtl/pss_ctrl.sv
module pss_ctrl
  import pss_pkg::*;
#(
  parameter int VLEN = 256,
  localparam int PW    = VLEN / 8,
  localparam int NE64  = VLEN / 64,
  localparam int NE128 = VLEN / 128,
  localparam int EW    = $clog2(NE64)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              elem_wide_i,
  input  logic [CODE_W-1:0] idx_code_i,
  input  logic [VLEN-1:0]   vec_i,
  input  logic [PW-1:0]     pred_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] next_addr_i,
  input  logic              sp_misaligned_i,
  input  logic [MEM_W-1:0]  elem_data_i,
  input  logic              elem_active_i,
  input  logic              any_active_i,
  input  logic              wr_ready_i,
  output logic [VLEN-1:0]   vec_q_o,
  output logic [PW-1:0]     pred_q_o,
  output logic              wide_q_o,
  output logic [EW-1:0]     idx_q_o,
  output logic [ADDR_W-1:0] cur_addr_o,
  output logic              wr_valid_o,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [MEM_W-1:0]  wr_data_o,
  output logic              done_o,
  output logic              err_undef_o,
  output logic              err_align_o,
  output logic              busy_o
);
  pss_state_e        st_q, st_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [EW-1:0]     idx_q, idx_d;
  logic [VLEN-1:0]   vec_q;
  logic [PW-1:0]     pred_q;
  logic              wide_q, und_q, mis_q;
  logic              eu_q, eu_d, ea_q, ea_d;
  logic              accept, adv, last;
  logic [EW-1:0]     last_idx;

  always_comb begin
    accept   = (st_q == ST_IDLE) && start_i;
    last_idx = wide_q ? EW'(NE128 - 1) : EW'(NE64 - 1);
    last     = (idx_q == last_idx);
    adv      = (st_q == ST_RUN) && (!elem_active_i || wr_ready_i);
  end

  always_comb begin
    st_d   = st_q;
    addr_d = addr_q;
    idx_d  = idx_q;
    eu_d   = 1'b0;
    ea_d   = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (start_i) begin
          st_d   = ST_CHECK;
          addr_d = start_addr_i;
          idx_d  = '0;
        end
      end
      ST_CHECK: begin
        if (und_q) begin
          st_d = ST_IDLE;
          eu_d = 1'b1;
        end else if (mis_q && any_active_i) begin
          st_d = ST_IDLE;
          ea_d = 1'b1;
        end else begin
          st_d = ST_RUN;
        end
      end
      ST_RUN: begin
        if (adv) begin
          if (last) begin
            st_d = ST_DONE;
          end else begin
            idx_d  = idx_q + EW'(1);
            addr_d = next_addr_i;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      addr_q <= '0;
      idx_q  <= '0;
      eu_q   <= 1'b0;
      ea_q   <= 1'b0;
    end else begin
      st_q   <= st_d;
      addr_q <= addr_d;
      idx_q  <= idx_d;
      eu_q   <= eu_d;
      ea_q   <= ea_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_q  <= '0;
      pred_q <= '0;
      wide_q <= 1'b0;
      und_q  <= 1'b0;
      mis_q  <= 1'b0;
    end else if (accept) begin
      vec_q  <= vec_i;
      pred_q <= pred_i;
      wide_q <= elem_wide_i;
      und_q  <= (idx_code_i == CODE_SPECIAL);
      mis_q  <= sp_misaligned_i;
    end
  end

  assign vec_q_o     = vec_q;
  assign pred_q_o    = pred_q;
  assign wide_q_o    = wide_q;
  assign idx_q_o     = idx_q;
  assign cur_addr_o  = addr_q;
  assign wr_valid_o  = (st_q == ST_RUN) && elem_active_i;
  assign wr_addr_o   = addr_q;
  assign wr_data_o   = elem_data_i;
  assign done_o      = (st_q == ST_DONE);
  assign err_undef_o = eu_q;
  assign err_align_o = ea_q;
  assign busy_o      = (st_q != ST_IDLE);

  a_r9_hold_stalled: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid_o && !wr_ready_i) |=> (wr_valid_o && $stable(wr_addr_o) && $stable(wr_data_o)));

  a_r2_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    (adv && !last) |=> (cur_addr_o == $past(cur_addr_o) + 64'd8));

  a_r10_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);

  a_r6_undef_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK && und_q) |=> (err_undef_o && !busy_o && !wr_valid_o));

  a_r7_align_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_CHECK && !und_q && mis_q && any_active_i) |=> (err_align_o && !busy_o));

  a_r11_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done_o, err_undef_o, err_align_o}));
endmodule

// File: rtl/pss_top.sv
module pss_top
  import pss_pkg::*;
#(
  parameter int VLEN = 256,
  localparam int PW = VLEN / 8,
  localparam int EW = $clog2(VLEN / 64)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              elem_wide_i,
  input  logic [CODE_W-1:0] idx_code_i,
  input  logic [CODE_W-1:0] base_code_i,
  input  logic [VLEN-1:0]   vec_i,
  input  logic [PW-1:0]     pred_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [ADDR_W-1:0] sp_i,
  input  logic [ADDR_W-1:0] index_i,
  output logic              wr_valid_o,
  input  logic              wr_ready_i,
  output logic [ADDR_W-1:0] wr_addr_o,
  output logic [MEM_W-1:0]  wr_data_o,
  output logic              done_o,
  output logic              err_undef_o,
  output logic              err_align_o,
  output logic              busy_o
);
  logic              rst_n_s;
  logic [ADDR_W-1:0] start_addr, next_addr, cur_addr;
  logic              sp_mis;
  logic [VLEN-1:0]   vec_q;
  logic [PW-1:0]     pred_q;
  logic              wide_q;
  logic [EW-1:0]     idx_q;
  logic [MEM_W-1:0]  elem_data;
  logic              elem_active, any_active;

  pss_rst_sync u_rst (
    .clk     (clk),
    .rst_n_a (rst_n),
    .rst_n_s (rst_n_s)
  );

  pss_addr_gen u_addr (
    .base_code_i     (base_code_i),
    .base_i          (base_i),
    .sp_i            (sp_i),
    .index_i         (index_i),
    .cur_addr_i      (cur_addr),
    .start_addr_o    (start_addr),
    .next_addr_o     (next_addr),
    .sp_misaligned_o (sp_mis)
  );

  pss_elem_sel #(.VLEN(VLEN)) u_sel (
    .vec_i        (vec_q),
    .pred_i       (pred_q),
    .wide_i       (wide_q),
    .idx_i        (idx_q),
    .data_o       (elem_data),
    .active_o     (elem_active),
    .any_active_o (any_active)
  );

  pss_ctrl #(.VLEN(VLEN)) u_ctrl (
    .clk             (clk),
    .rst_n           (rst_n_s),
    .start_i         (start_i),
    .elem_wide_i     (elem_wide_i),
    .idx_code_i      (idx_code_i),
    .vec_i           (vec_i),
    .pred_i          (pred_i),
    .start_addr_i    (start_addr),
    .next_addr_i     (next_addr),
    .sp_misaligned_i (sp_mis),
    .elem_data_i     (elem_data),
    .elem_active_i   (elem_active),
    .any_active_i    (any_active),
    .wr_ready_i      (wr_ready_i),
    .vec_q_o         (vec_q),
    .pred_q_o        (pred_q),
    .wide_q_o        (wide_q),
    .idx_q_o         (idx_q),
    .cur_addr_o      (cur_addr),
    .wr_valid_o      (wr_valid_o),
    .wr_addr_o       (wr_addr_o),
    .wr_data_o       (wr_data_o),
    .done_o          (done_o),
    .err_undef_o     (err_undef_o),
    .err_align_o     (err_align_o),
    .busy_o          (busy_o)
  );
endmodule

// File: tb/tb_pss_top.sv
module tb_pss_top;
  localparam int VLEN = 256;
  localparam int PW   = VLEN / 8;

  typedef struct packed {
    logic        wide;
    logic [4:0]  icode;
    logic [4:0]  bcode;
    logic [63:0] base;
    logic [63:0] sp;
    logic [63:0] index;
    logic [31:0] pred;
    logic [7:0]  seed;
    logic        stall;
  } vec_t;

  localparam int NV = 11;
  localparam vec_t TBL [NV] = '{
    '{1'b0, 5'd2,  5'd3,  64'h1000, 64'h0, 64'h4, 32'hFFFF_FFFF, 8'h11, 1'b0},
    '{1'b0, 5'd7,  5'd0,  64'h4000, 64'h0, 64'h2, 32'h0100_0001, 8'h22, 1'b1},
    '{1'b1, 5'd1,  5'd5,  64'h8000, 64'h0, 64'h0, 32'h0001_0001, 8'h33, 1'b1},
    '{1'b1, 5'd1,  5'd5,  64'h8000, 64'h0, 64'h3, 32'h0001_0100, 8'h44, 1'b0},
    '{1'b0, 5'd4,  5'd6,  64'h9000, 64'h0, 64'h1, 32'h0000_0000, 8'h55, 1'b0},
    '{1'b0, 5'd4,  5'd31, 64'hDEAD_0000, 64'h2000, 64'h1, 32'h0000_00FF, 8'h66, 1'b1},
    '{1'b0, 5'd4,  5'd31, 64'hDEAD_0000, 64'h2008, 64'h0, 32'h0000_0001, 8'h77, 1'b0},
    '{1'b1, 5'd4,  5'd31, 64'hDEAD_0000, 64'h2004, 64'h0, 32'h0000_FF00, 8'h88, 1'b0},
    '{1'b0, 5'd31, 5'd2,  64'h3000, 64'h0, 64'h0, 32'hFFFF_FFFF, 8'h99, 1'b0},
    '{1'b0, 5'd9,  5'd9,  64'hFFFF_FFFF_FFFF_FFF0, 64'h0, 64'h1, 32'h0101_0101, 8'hAA, 1'b1},
    '{1'b1, 5'd9,  5'd9,  64'h10, 64'h0, 64'h1000_0000_0000_0001, 32'h0001_0001, 8'hBB, 1'b0}
  };

  logic              clk;
  logic              rst_n;
  logic              start_i;
  logic              elem_wide_i;
  logic [4:0]        idx_code_i;
  logic [4:0]        base_code_i;
  logic [VLEN-1:0]   vec_i;
  logic [PW-1:0]     pred_i;
  logic [63:0]       base_i, sp_i, index_i;
  logic              wr_valid_o, wr_ready_i;
  logic [63:0]       wr_addr_o, wr_data_o;
  logic              done_o, err_undef_o, err_align_o, busy_o;

  int n_chk;
  int n_bad;
  int cyc;

  pss_top #(.VLEN(VLEN)) dut (
    .clk (clk), .rst_n (rst_n), .start_i (start_i), .elem_wide_i (elem_wide_i),
    .idx_code_i (idx_code_i), .base_code_i (base_code_i), .vec_i (vec_i),
    .pred_i (pred_i), .base_i (base_i), .sp_i (sp_i), .index_i (index_i),
    .wr_valid_o (wr_valid_o), .wr_ready_i (wr_ready_i), .wr_addr_o (wr_addr_o),
    .wr_data_o (wr_data_o), .done_o (done_o), .err_undef_o (err_undef_o),
    .err_align_o (err_align_o), .busy_o (busy_o)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic report_done();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    cyc = 0;
    forever begin
      @(posedge clk);
      cyc++;
      if (cyc > 100000) begin
        n_chk++;
        n_bad++;
        $display("FAIL watchdog: run hung, actual %0d cycles expected < 100000", cyc);
        report_done();
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] word_of(input logic [7:0] s, input int w);
    return {s, 24'hA1B2C3, 24'(w), 8'(s ^ 8'(w))};
  endfunction

  task automatic run_op(input vec_t v, input bit poke);
    logic [63:0] ea [4];
    logic [63:0] ed [4];
    int n, got, esz, ne;
    logic [63:0] sa, ha, hd;
    bit hold, saw_done, saw_eu, saw_ea, timed_out, exp_eu, exp_ea, any;
    n = 0; got = 0; hold = 0; saw_done = 0; saw_eu = 0; saw_ea = 0; timed_out = 1;
    ha = '0; hd = '0; any = 0;
    esz = v.wide ? 128 : 64;
    ne  = VLEN / esz;
    sa  = ((v.bcode == 5'd31) ? v.sp : v.base) + (v.index << 3);
    for (int e = 0; e < ne; e++) begin
      if (v.pred[e * esz / 8]) begin
        ea[n] = sa + 64'(8 * e);
        ed[n] = word_of(v.seed, e * esz / 64);
        n++;
        any = 1;
      end
    end
    exp_eu = (v.icode == 5'd31);
    exp_ea = !exp_eu && (v.bcode == 5'd31) && (v.sp[3:0] != 4'd0) && any;
    if (exp_eu || exp_ea) n = 0;

    @(negedge clk);
    elem_wide_i = v.wide; idx_code_i = v.icode; base_code_i = v.bcode;
    base_i = v.base; sp_i = v.sp; index_i = v.index; pred_i = v.pred;
    for (int w = 0; w < VLEN / 64; w++) vec_i[w*64 +: 64] = word_of(v.seed, w);
    start_i = 1'b1;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      wr_ready_i = v.stall ? (c % 3 == 2) : 1'b1;
      if (poke && c == 2) begin
        start_i = 1'b1; idx_code_i = 5'd31; pred_i = '0;
      end else begin
        start_i = 1'b0; idx_code_i = v.icode; pred_i = v.pred;
      end
      #1;
      if (poke && c == 2) chk(busy_o, "R10 busy", 64'(busy_o), 64'd1);
      if (hold) begin
        chk(wr_valid_o && wr_addr_o == ha && wr_data_o == hd, "R9 hold", wr_addr_o, ha);
        hold = 0;
      end
      if (wr_valid_o && !wr_ready_i) begin
        hold = 1; ha = wr_addr_o; hd = wr_data_o;
      end
      if (wr_valid_o && wr_ready_i) begin
        if (got < n) begin
          chk(wr_addr_o == ea[got], (got == 0) ? "R1 start addr" : "R2 addr", wr_addr_o, ea[got]);
          chk(wr_data_o == ed[got], v.wide ? "R5 data" : "R4 data", wr_data_o, ed[got]);
        end else begin
          chk(1'b0, "R3 extra write", wr_addr_o, 64'(n));
        end
        got++;
      end
      if (done_o)      saw_done = 1;
      if (err_undef_o) saw_eu = 1;
      if (err_align_o) saw_ea = 1;
      if (saw_done || saw_eu || saw_ea) begin
        timed_out = 0;
        break;
      end
    end
    start_i = 1'b0;
    chk(!timed_out, "R10 completion", 64'(timed_out), 64'd0);
    chk(got == n, "R3 write count", 64'(got), 64'(n));
    chk(saw_eu == exp_eu, "R6 undef flag", 64'(saw_eu), 64'(exp_eu));
    chk(saw_ea == exp_ea, "R7 align flag", 64'(saw_ea), 64'(exp_ea));
    chk(saw_done == !(exp_eu || exp_ea), (v.bcode == 5'd31) ? "R8 done" : "R10 done",
        64'(saw_done), 64'(!(exp_eu || exp_ea)));
    @(negedge clk);
    #1;
    chk(!done_o && !err_undef_o && !err_align_o && !busy_o, "R10 single pulse",
        {60'd0, done_o, err_undef_o, err_align_o, busy_o}, 64'd0);
  endtask

  initial begin
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; start_i = 1'b0; elem_wide_i = 1'b0; idx_code_i = '0;
    base_code_i = '0; vec_i = '0; pred_i = '0; base_i = '0; sp_i = '0;
    index_i = '0; wr_ready_i = 1'b1;
    repeat (3) @(negedge clk);
    // R11: outputs quiet while reset is held
    chk({wr_valid_o, done_o, err_undef_o, err_align_o, busy_o} == 5'd0, "R11 in reset",
        64'({wr_valid_o, done_o, err_undef_o, err_align_o, busy_o}), 64'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk({wr_valid_o, done_o, err_undef_o, err_align_o, busy_o} == 5'd0, "R11 after reset",
        64'({wr_valid_o, done_o, err_undef_o, err_align_o, busy_o}), 64'd0);

    for (int i = 0; i < NV; i++) run_op(TBL[i], 1'b0);

    // R10: start while busy is ignored; running op finishes unchanged
    run_op('{1'b0, 5'd3, 5'd3, 64'h7000, 64'h0, 64'h5, 32'h0101_0101, 8'hCC, 1'b1}, 1'b1);

    // R8: misaligned stack pointer in wide mode with only non-element predicate bits set
    run_op('{1'b1, 5'd0, 5'd31, 64'h0, 64'h200F, 64'h0, 32'hFEFE_FEFE, 8'hDD, 1'b0}, 1'b0);

    report_done();
  end
endmodule